// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address for a synchronous burst memory. A new start address is captured whenever either of two independent address strobes is high at a rising clock edge. From then on the block walks through a four-word burst, and it steps forward only on edges where the advance input is high. Only the two least significant address bits are rewritten. All higher bits stay as they were loaded.

An order-select input chooses how the low bits move. In the wrapping increment order, the low bits count up modulo four from the loaded value. In the interleaved order, the low bits are the loaded low bits XORed with a burst count that runs 0, 1, 2, 3. The order is captured together with the address, so it stays fixed for the whole burst.

Order value 1 means interleaved. A board-level pull-up on an unconnected pin therefore gives the interleaved order. Because a strobe may be given on every cycle, the burst feature can be ignored entirely and the block then acts as a plain registered address path.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is asserted, and after it is released, the output is 0 and the burst count is 0. The captured order resets to interleaved, so the first advance after reset yields address 1.
- R2: A high `strb_a_i` at a rising edge captures `addr_i`. The output equals that address from that edge until the next edge that changes the state.
- R3: A high `strb_b_i` at a rising edge captures `addr_i` exactly as `strb_a_i` does. Both strobes high together act as a single load.
- R4: At an edge with both strobes low and `adv_i` low, the output does not change. This holds whatever value `order_i` has at that edge.
- R5: At an edge where a strobe and `adv_i` are both high, the load wins. The burst count restarts at 0, so the output equals the new address.
- R6: Output bits above bit 1 always equal the loaded address bits above bit 1. This holds throughout a burst and across a wrap of the low bits.
- R7: In linear order (captured `order_i` = 0), each advance raises the low two bits by 1 modulo 4, for example 1,2,3,0. A fourth advance returns to the loaded value.
- R8: In interleaved order (captured `order_i` = 1), the low two bits equal the loaded low bits XOR the count, for example 2,3,0,1 for loaded value 2.
- R9: `order_i` is sampled only at a load edge. Changing it during a burst has no effect on the sequence.
- R10: Loads on consecutive edges each show their own address on the output in the cycle after their edge. No cycle is lost between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | AW | External start address |
| strb_a_i | input | 1 | First address strobe, loads `addr_i` |
| strb_b_i | input | 1 | Second address strobe, loads `addr_i` |
| adv_i | input | 1 | Burst advance enable |
| order_i | input | 1 | Burst order at load: 0 linear, 1 interleaved |
| burst_addr_o | output | AW | Current burst address |

## Verification
Every result here is due one clock after its cause. A load or an advance sampled at a rising edge shows on `burst_addr_o` within that same cycle, because the output is formed from registers with no further stage. The bench therefore drives inputs 1 time unit after a rising edge and compares the output 1 time unit after the following rising edge. The reset value is compared while reset is still held and again right after an asynchronous reset in the middle of a burst. The mode-change and hold cases are observed on the address output itself.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;

endpackage

// File: rtl/burst_load_ctl.sv
module burst_load_ctl
    import burst_addr_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr_i,
    input  logic          strb_a_i,
    input  logic          strb_b_i,
    input  logic          adv_i,
    input  logic          order_i,
    output logic [AW-1:0] base_o,
    output logic [CW-1:0] cnt_o,
    output order_e        order_o
);

    typedef struct packed {
        logic [AW-1:0] base;
        logic [CW-1:0] cnt;
        order_e        order;
    } state_t;

    state_t st_d;
    state_t st_q;
    logic   load;

    assign load = strb_a_i | strb_b_i;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.base  = addr_i;
            st_d.cnt   = '0;
            st_d.order = order_e'(order_i);
        end else if (adv_i) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.base  <= '0;
            st_q.cnt   <= '0;
            st_q.order <= ORD_INTERLEAVE;
        end else begin
            st_q <= st_d;
        end
    end

    assign base_o  = st_q.base;
    assign cnt_o   = st_q.cnt;
    assign order_o = st_q.order;

endmodule

// File: rtl/burst_low_map.sv
module burst_low_map
    import burst_addr_pkg::*;
#(
    parameter int CW = 2
) (
    input  logic [CW-1:0] base_low_i,
    input  logic [CW-1:0] cnt_i,
    input  order_e        order_i,
    output logic [CW-1:0] low_o
);

    logic [CW-1:0] lin_low;
    logic [CW-1:0] ilv_low;

    always_comb begin
        lin_low = base_low_i + cnt_i;
        ilv_low = base_low_i ^ cnt_i;
        low_o   = (order_i == ORD_LINEAR) ? lin_low : ilv_low;
    end

endmodule

// File: rtl/burst_addr_join.sv
module burst_addr_join #(
    parameter int AW = 32,
    parameter int CW = 2
) (
    input  logic [AW-1:0] base_i,
    input  logic [CW-1:0] low_i,
    output logic [AW-1:0] addr_o
);

    localparam int UW = AW - CW;

    generate
        if (UW > 0) begin : g_upper
            assign addr_o = {base_i[AW-1:CW], low_i};
        end else begin : g_low_only
            logic unused_base;
            assign unused_base = ^base_i;
            assign addr_o      = low_i;
        end
    endgenerate

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_addr_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr_i,
    input  logic          strb_a_i,
    input  logic          strb_b_i,
    input  logic          adv_i,
    input  logic          order_i,
    output logic [AW-1:0] burst_addr_o
);

    logic [AW-1:0] base_q;
    logic [CW-1:0] cnt_q;
    order_e        ord_q;
    logic [CW-1:0] low_d;

    burst_load_ctl #(.AW(AW), .CW(CW)) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_i   (addr_i),
        .strb_a_i (strb_a_i),
        .strb_b_i (strb_b_i),
        .adv_i    (adv_i),
        .order_i  (order_i),
        .base_o   (base_q),
        .cnt_o    (cnt_q),
        .order_o  (ord_q)
    );

    burst_low_map #(.CW(CW)) u_map (
        .base_low_i (base_q[CW-1:0]),
        .cnt_i      (cnt_q),
        .order_i    (ord_q),
        .low_o      (low_d)
    );

    burst_addr_join #(.AW(AW), .CW(CW)) u_join (
        .base_i (base_q),
        .low_i  (low_d),
        .addr_o (burst_addr_o)
    );

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
    parameter int AW = 32,
    parameter int CW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] addr_i,
    input logic          strb_a_i,
    input logic          strb_b_i,
    input logic          adv_i,
    input logic          ord_q,
    input logic [AW-1:0] burst_addr_o
);

    logic ld;
    assign ld = strb_a_i | strb_b_i;

    AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> burst_addr_o == $past(addr_i)); // R2

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && adv_i) |=> burst_addr_o == $past(addr_i)); // R5

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && !adv_i) |=> $stable(burst_addr_o)); // R4

    AST_UPPER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> $stable(burst_addr_o[AW-1:CW])); // R6

    AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && adv_i && !ord_q) |=>
            burst_addr_o[CW-1:0] == CW'($past(burst_addr_o[CW-1:0]) + 1'b1)); // R7

    AST_ILV_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && adv_i && ord_q) |=> burst_addr_o != $past(burst_addr_o)); // R8

    AST_ORDER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> $stable(ord_q)); // R9

endmodule

bind burst_addr_gen burst_addr_gen_chk #(.AW(AW), .CW(CW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr_i       (addr_i),
    .strb_a_i     (strb_a_i),
    .strb_b_i     (strb_b_i),
    .adv_i        (adv_i),
    .ord_q        (ord_q),
    .burst_addr_o (burst_addr_o)
);

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int NV = 16;

    typedef struct packed {
        logic          sa;
        logic          sb;
        logic          adv;
        logic          ord;
        logic [AW-1:0] addr;
        logic [AW-1:0] exp;
    } vec_t;

    // sa, sb, adv, ord, addr, expected output after the edge
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b0, 1'b0, 1'b0, 8'hA5, 8'hA5}, // R2 load, linear
        '{1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'hA6}, // R7
        '{1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'hA7}, // R7
        '{1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'hA4}, // R6 R7 wrap keeps upper
        '{1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'hA5}, // R7 fourth advance returns
        '{1'b0, 1'b1, 1'b0, 1'b1, 8'h3E, 8'h3E}, // R3 load, interleaved
        '{1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 8'h3F}, // R8 k=1
        '{1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h3C}, // R8 R9 k=2, order change ignored
        '{1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 8'h3C}, // R4 hold
        '{1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h3D}, // R8 R9 k=3
        '{1'b1, 1'b0, 1'b1, 1'b1, 8'h71, 8'h71}, // R5 strobe beats advance
        '{1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 8'h70}, // R5 R8 count restarted
        '{1'b0, 1'b1, 1'b0, 1'b1, 8'h12, 8'h12}, // R10 back to back
        '{1'b1, 1'b0, 1'b0, 1'b1, 8'h93, 8'h93}, // R10
        '{1'b1, 1'b1, 1'b0, 1'b0, 8'h44, 8'h44}, // R3 both strobes
        '{1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h45}  // R7 linear from both-strobe load
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic          strb_a_i = 1'b0;
    logic          strb_b_i = 1'b0;
    logic          adv_i = 1'b0;
    logic          order_i = 1'b1;
    logic [AW-1:0] burst_addr_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_addr_gen #(.AW(AW), .CW(2)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .addr_i       (addr_i),
        .strb_a_i     (strb_a_i),
        .strb_b_i     (strb_b_i),
        .adv_i        (adv_i),
        .order_i      (order_i),
        .burst_addr_o (burst_addr_o)
    );

    task automatic check(input string req, input logic [AW-1:0] exp);
        total++;
        if (burst_addr_o !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, burst_addr_o, exp);
        end
    endtask

    task automatic drive(input logic sa, input logic sb, input logic adv,
                         input logic ord, input logic [AW-1:0] a);
        strb_a_i = sa;
        strb_b_i = sb;
        adv_i    = adv;
        order_i  = ord;
        addr_i   = a;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset value", 8'h00);
        rst_n = 1'b1;
        drive(1'b0, 1'b0, 1'b1, 1'b1, 8'h00);
        @(posedge clk);
        #1;
        check("R1 first advance from count 0", 8'h01);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].sa, VEC[i].sb, VEC[i].adv, VEC[i].ord, VEC[i].addr);
            @(posedge clk);
            #1;
            check($sformatf("vector %0d", i), VEC[i].exp);
        end

        // R4: idle edge with order toggled, address unchanged
        drive(1'b0, 1'b0, 1'b0, 1'b1, 8'hEE);
        @(posedge clk);
        #1;
        check("R4 idle with order change", 8'h45);

        // R1: asynchronous reset in the middle of a burst
        drive(1'b1, 1'b0, 1'b0, 1'b1, 8'hC2);
        @(posedge clk);
        #1;
        drive(1'b0, 1'b0, 1'b1, 1'b1, 8'h00);
        @(posedge clk);
        #1;
        check("R8 interleaved step from C2", 8'hC3);
        drive(1'b0, 1'b0, 1'b0, 1'b1, 8'h00);
        rst_n = 1'b0;
        #1;
        check("R1 reset mid burst", 8'h00);
        @(posedge clk);
        #1;
        rst_n = 1'b1;

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule